// File: doc/BRIEF.md
# Protected Timed Program Controller

This block sits behind a serial command decoder in a small non-volatile memory model. The decoder hands it one fully received command at a time: a single-word store, a single-word clear, a fill of every word with one value, a clear of every word, and the two commands that open and close a sticky write-permission latch. The controller keeps that latch, watches for the chip-select release that has to follow a store or clear, and then runs a fixed-length busy interval. When the interval ends, it applies the change to a register array.

A store or clear command only arms the controller. It launches only if chip select is released after the command's final bit and before the next serial clock rising edge. If the serial clock edge arrives first, the armed command is dropped. Once a cycle is running, it needs no serial clock. It counts `PROG_CYCLES` system clocks with `busy` high and rejects every new command. The array can be viewed as full words or as byte lanes, chosen by `orgWide`. The read port always returns a whole word and does not depend on the latch.

Top module: `writeProgCtl`

## Requirements
- R1: After reset, `busy` is 0, the write-permission latch is closed, and every array word reads all ones.
- R2: While the latch is closed, store and clear commands (`cmdOp` 1 to 4) never start a cycle and leave the array unchanged.
- R3: `cmdOp`=5 opens the latch and `cmdOp`=6 closes it. Each takes effect on the next command, and the latch stays as set until the opposite command or a reset. `rdData` is the same whatever the latch state.
- R4: An accepted store or clear arms the controller. A `csFall` pulse in a later cycle, with no `skRise` between, raises `busy` on the clock edge that samples the `csFall`.
- R5: A `skRise` pulse while armed drops the armed command. No cycle starts, and a later `csFall` has no effect.
- R6: `busy` stays high for exactly `PROG_CYCLES` clocks. The array does not change while `busy` is high, and the new contents are readable from the first cycle with `busy` low.
- R7: `cmdOp`=1 (store) with `orgWide`=1 replaces word `cmdAddr[AW-1:0]` with `cmdData`. With `orgWide`=0 it writes `cmdData[7:0]` into word `cmdAddr[AW:1]` only: the high byte when `cmdAddr[0]`=1, the low byte when it is 0.
- R8: `cmdOp`=2 (clear) sets the addressed word (wide mode) or the addressed byte lane (byte mode) to all ones and leaves everything else unchanged.
- R9: `cmdOp`=3 (fill) writes `cmdData` to every word in wide mode. In byte mode it writes `cmdData[7:0]` to both lanes of every word.
- R10: `cmdOp`=4 (clear all) sets every bit of every word to 1.
- R11: While `busy` is high, every command is ignored, including latch commands and stores.
- R12: A `csFall` in the same cycle as the `cmdValid` that delivers the command does not launch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| orgWide | input | 1 | 1 = full-word organization, 0 = byte-lane organization |
| cmdValid | input | 1 | One-cycle pulse: a decoded command is present |
| cmdOp | input | 3 | 1 store, 2 clear, 3 fill all, 4 clear all, 5 open latch, 6 close latch |
| cmdAddr | input | AW+1 | Command address (byte address in byte mode) |
| cmdData | input | WORD_W | Command data |
| skRise | input | 1 | One-cycle pulse per serial clock rising edge |
| csFall | input | 1 | One-cycle pulse when chip select is released |
| busy | output | 1 | High while a program cycle runs |
| rdAddr | input | AW | Word index for the read port |
| rdData | output | WORD_W | Word at `rdAddr` |

## Verification
A `csFall` sampled at edge L shows `busy` high after L. `busy` stays high for `PROG_CYCLES` edges and drops at L+`PROG_CYCLES`, and the new array contents appear at that same edge. A latch command takes effect one edge after its `cmdValid`. The bench drives every pulse on a falling edge and samples on falling edges. It counts the falling edges with `busy` high and compares that count with `PROG_CYCLES`. Array checks are queued only once `busy` is seen low, and the monitor reads them back one word per falling edge.

// File: rtl/progPkg.sv
package progPkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_STORE = 3'd1,
    OP_CLEAR = 3'd2,
    OP_FILL  = 3'd3,
    OP_CLALL = 3'd4,
    OP_OPEN  = 3'd5,
    OP_CLOSE = 3'd6
  } progOp_e;

  // strobes from control to the array datapath
  typedef struct packed {
    logic capture;   // latch address, data and organization
    logic commit;    // apply the pending change this edge
    logic allWords;  // pending change targets every word
    logic fillOnes;  // pending change writes ones instead of data
  } arrayStrobe_t;
endpackage

// File: rtl/progCtrl.sv
module progCtrl
  import progPkg::*;
#(
  parameter int PROG_CYCLES = 500000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdOp,
  input  logic         skRise,
  input  logic         csFall,
  output arrayStrobe_t stb,
  output logic         busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

  progOp_e opC;
  logic permit, armed, pendAll, pendFill;
  logic accept, isProg, launch;
  logic [CNT_W-1:0] remain;

  always_comb begin
    opC    = progOp_e'(cmdOp);
    isProg = (opC == OP_STORE) || (opC == OP_CLEAR) ||
             (opC == OP_FILL)  || (opC == OP_CLALL);
    accept = cmdValid && !busy;
    launch = armed && csFall && !cmdValid && !busy;
    stb.capture  = accept && isProg && permit;
    stb.commit   = busy && (remain == '0);
    stb.allWords = pendAll;
    stb.fillOnes = pendFill;
  end

  // sticky write-permission latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) permit <= 1'b0;
    else if (accept && opC == OP_OPEN) permit <= 1'b1;
    else if (accept && opC == OP_CLOSE) permit <= 1'b0;
  end

  // launch window: open after the command, closed by a clock edge or deselect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      pendAll  <= 1'b0;
      pendFill <= 1'b0;
    end else if (accept) begin
      armed <= stb.capture;
      if (stb.capture) begin
        pendAll  <= (opC == OP_FILL) || (opC == OP_CLALL);
        pendFill <= (opC == OP_CLEAR) || (opC == OP_CLALL);
      end
    end else if (skRise || csFall) begin
      armed <= 1'b0;
    end
  end

  // self-timed busy interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      remain <= LOAD;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/progArray.sv
module progArray
  import progPkg::*;
#(
  parameter int WORDS  = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arrayStrobe_t      stb,
  input  logic              orgWide,
  input  logic [$clog2(WORDS):0]   cmdAddr,
  input  logic [WORD_W-1:0]        cmdData,
  input  logic [$clog2(WORDS)-1:0] rdAddr,
  output logic [WORD_W-1:0]        rdData
);
  localparam int AW     = $clog2(WORDS);
  localparam int BYTE_W = WORD_W / 2;

  logic [AW:0]       pAddr;
  logic [WORD_W-1:0] pData;
  logic              pWide;
  logic [AW-1:0]     tgtWord;
  logic              tgtHigh;
  logic [WORD_W-1:0] wideVal;
  logic [BYTE_W-1:0] byteVal;
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pAddr <= '0;
      pData <= '0;
      pWide <= 1'b1;
    end else if (stb.capture) begin
      pAddr <= cmdAddr;
      pData <= cmdData;
      pWide <= orgWide;
    end
  end

  always_comb begin
    tgtWord = pWide ? pAddr[AW-1:0] : pAddr[AW:1];
    tgtHigh = pAddr[0];
    wideVal = stb.fillOnes ? '1 : pData;
    byteVal = stb.fillOnes ? '1 : pData[BYTE_W-1:0];
  end

  for (genvar w = 0; w < WORDS; w++) begin : gWord
    logic hit;
    logic [WORD_W-1:0] nextVal;
    always_comb begin
      hit = stb.allWords || (tgtWord == AW'(w));
      if (pWide) nextVal = wideVal;
      else if (stb.allWords) nextVal = {byteVal, byteVal};
      else if (tgtHigh) nextVal = {byteVal, mem[w][BYTE_W-1:0]};
      else nextVal = {mem[w][WORD_W-1:BYTE_W], byteVal};
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[w] <= '1;
      else if (stb.commit && hit) mem[w] <= nextVal;
    end
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/writeProgCtl.sv
module writeProgCtl
  import progPkg::*;
#(
  parameter int WORDS       = 32,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     orgWide,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic [$clog2(WORDS):0]   cmdAddr,
  input  logic [WORD_W-1:0]        cmdData,
  input  logic                     skRise,
  input  logic                     csFall,
  output logic                     busy,
  input  logic [$clog2(WORDS)-1:0] rdAddr,
  output logic [WORD_W-1:0]        rdData
);
  arrayStrobe_t stb;

  progCtrl #(.PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .skRise(skRise), .csFall(csFall), .stb(stb), .busy(busy)
  );

  progArray #(.WORDS(WORDS), .WORD_W(WORD_W)) uArray (
    .clk(clk), .rstN(rstN), .stb(stb), .orgWide(orgWide),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/writeProgChk.sv
module writeProgChk #(
  parameter int WORDS       = 32,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500000
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cmdValid,
  input logic                     skRise,
  input logic                     csFall,
  input logic                     busy,
  input logic [$clog2(WORDS)-1:0] rdAddr,
  input logic [WORD_W-1:0]        rdData
);
  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R4
  busy_rise_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csFall));

  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == PROG_CYCLES);

  // R6
  array_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $stable(rdAddr) |-> $stable(rdData));

  // R5
  idle_no_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !csFall |=> !busy);

  // R12
  same_cycle_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cmdValid && csFall |=> !busy);
endmodule

bind writeProgCtl writeProgChk #(
  .WORDS(WORDS), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)
) uChk (.*);

// File: tb/tb_writeProgCtl.sv
module tb_writeProgCtl;
  localparam int WORDS = 8;
  localparam int WORD_W = 16;
  localparam int P = 20;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic orgWide = 1'b1;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [AW:0] cmdAddr = '0;
  logic [WORD_W-1:0] cmdData = '0;
  logic skRise = 1'b0;
  logic csFall = 1'b0;
  logic busy;
  logic [AW-1:0] rdAddr = '0;
  logic [WORD_W-1:0] rdData;

  writeProgCtl #(.WORDS(WORDS), .WORD_W(WORD_W), .PROG_CYCLES(P)) dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    int idx;
    logic [WORD_W-1:0] exp;
    string tag;
  } sbItem_t;

  sbItem_t sbq[$];
  logic [WORD_W-1:0] mdl [WORDS];
  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words and compares them against the read port
  always begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      sbItem_t it;
      it = sbq.pop_front();
      rdAddr = AW'(it.idx);
      #1;
      check(rdData === it.exp, it.tag, 32'(rdData), 32'(it.exp));
    end
  end

  task automatic pushAll(input string tag);
    for (int i = 0; i < WORDS; i++) begin
      sbItem_t it;
      it.idx = i; it.exp = mdl[i]; it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    @(negedge clk);
    #2;
  endtask

  task automatic applyModel(input int op, input logic [AW:0] a, input logic [WORD_W-1:0] d, input bit wide);
    logic [7:0] b;
    b = (op == 2 || op == 4) ? 8'hFF : d[7:0];
    case (op)
      1, 2: begin
        if (wide) mdl[a[AW-1:0]] = (op == 2) ? '1 : d;
        else if (a[0]) mdl[a[AW:1]][15:8] = b;
        else mdl[a[AW:1]][7:0] = b;
      end
      3: for (int i = 0; i < WORDS; i++) mdl[i] = wide ? d : {b, b};
      4: for (int i = 0; i < WORDS; i++) mdl[i] = '1;
      default: ;
    endcase
  endtask

  task automatic sendCmd(input int op, input logic [AW:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseCs();
    csFall = 1'b1;
    @(negedge clk);
    csFall = 1'b0;
  endtask

  // count falling edges with busy high, starting at the current falling edge
  task automatic busyCount(output int n);
    n = 0;
    while (busy === 1'b1 && n < 4 * P) begin
      n++;
      @(negedge clk);
    end
  endtask

  // full program command: command, deselect, then measure the busy interval
  task automatic prog(input int op, input logic [AW:0] a, input logic [WORD_W-1:0] d,
                      input bit expectRun, input string tag);
    int n;
    sendCmd(op, a, d);
    pulseCs();
    busyCount(n);
    check(n == (expectRun ? P : 0), {tag, " busy cycles"}, 32'(n), expectRun ? P : 0);
    if (expectRun) applyModel(op, a, d, orgWide);
    pushAll({tag, " array"});
    drain();
  endtask

  initial begin
    int n;
    for (int i = 0; i < WORDS; i++) mdl[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);
    pushAll("R1 reset contents");
    drain();

    // R2: latch closed, stores and clears ignored
    prog(1, 4'd3, 16'hA5C3, 1'b0, "R2 store while closed");
    prog(4, 4'd0, 16'h0000, 1'b0, "R2 clear-all while closed");

    // R3 open latch, R4 R6 R7 wide store
    sendCmd(5, '0, '0);
    prog(1, 4'd3, 16'hA5C3, 1'b1, "R7 R4 R6 wide store");
    prog(1, 4'd6, 16'h0F0F, 1'b1, "R7 wide store word6");

    // R7 byte lanes
    orgWide = 1'b0;
    prog(1, 4'd5, 16'h773C, 1'b1, "R7 byte store high lane");
    prog(1, 4'd4, 16'h0011, 1'b1, "R7 byte store low lane");

    // R5 abort by serial clock edge before deselect
    sendCmd(1, 4'd8, 16'h0022);
    skRise = 1'b1; @(negedge clk); skRise = 1'b0;
    pulseCs();
    busyCount(n);
    check(n == 0, "R5 aborted launch", 32'(n), 0);
    pushAll("R5 array unchanged");
    drain();

    // R12 deselect in the same cycle as the command
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd1; cmdAddr = 4'd2; cmdData = 16'h0099; csFall = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; csFall = 1'b0;
    @(negedge clk);
    busyCount(n);
    check(n == 0, "R12 same-cycle deselect", 32'(n), 0);
    pushAll("R12 array unchanged");
    drain();

    // R8 clears
    prog(2, 4'd5, 16'h0000, 1'b1, "R8 byte clear");
    orgWide = 1'b1;
    prog(2, 4'd3, 16'h0000, 1'b1, "R8 wide clear");

    // R9 fills
    prog(3, 4'd0, 16'h1234, 1'b1, "R9 wide fill");
    orgWide = 1'b0;
    prog(3, 4'd0, 16'h005A, 1'b1, "R9 byte fill");
    orgWide = 1'b1;

    // R11 commands while busy are ignored
    sendCmd(1, 4'd1, 16'hBEEF);
    pulseCs();
    check(busy === 1'b1, "R11 busy started", 32'(busy), 1);
    sendCmd(6, '0, '0);
    sendCmd(1, 4'd2, 16'hDEAD);
    pulseCs();
    busyCount(n);
    check(n == P - 5, "R11 busy undisturbed", 32'(n), P - 5);
    applyModel(1, 4'd1, 16'hBEEF, 1'b1);
    pushAll("R11 only first store");
    drain();
    prog(1, 4'd7, 16'hC001, 1'b1, "R11 close ignored");

    // R3 close latch, reads still work, then reopen
    sendCmd(6, '0, '0);
    prog(3, 4'd0, 16'h0000, 1'b0, "R3 fill after close");
    sendCmd(5, '0, '0);
    // R10 clear all
    prog(4, 4'd0, 16'h0000, 1'b1, "R10 clear all");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule